// File: doc/BRIEF.md
# Secondary core power-up sequencer

This block brings one secondary processor core out of power-down in hardware. A start request names a core and carries a boot address. The block accepts it only when idle and the index is in range. It saves the address in a private register that all cores share. It then walks a fixed list of control writes, one per clock, with two timed pauses. The core's reset field goes low and its L1 cache is held in reset. Debug access is blocked. The power clamp opens one bit per step. After a long settle pause the power-off gate is removed. After a short pause the reset is released and debug access returns.

A mode input picks a reduced variant. That variant leaves out the debug handling, the clamp ramp and the long pause. The power switches and the cores are not part of the block. The outputs are the control bits those parts would read, plus busy, done and error flags. Both pauses are parameters given in clock cycles.

Top module: `core_pwrup_seq`

## Requirements
- R1: On an accepted start (start high, busy low, index below NUM_CORES) `boot_addr_reg` takes `boot_addr` at that clock edge and holds it until the next accepted start.
- R2: One cycle after acceptance the selected core's 2-bit reset field (bits [2k+1:2k] of `core_rst_ctrl`) becomes 2'b00.
- R3: Two cycles after acceptance bit k of `l1_run` is cleared. All other cores' bits keep their values.
- R4: In full mode (`reduced_mode` = 0) bit k of `dbg_en` clears three cycles after acceptance and is set again as the last step, 15+LONG_CYC+SHORT_CYC cycles after acceptance.
- R5: In full mode the core's clamp field (bits [8k+7:8k] of `clamp`) is written with 8'hFF >> i for i = 0..8, one write per cycle, from 4 to 12 cycles after acceptance. It ends at 8'h00.
- R6: In full mode bit k of `pwr_off` clears 13+LONG_CYC cycles after acceptance. This leaves a pause of LONG_CYC cycles after the last clamp write.
- R7: The reset field becomes 2'b11 a pause of SHORT_CYC cycles after the gate step. In full mode that is 14+LONG_CYC+SHORT_CYC cycles after acceptance.
- R8: In reduced mode `dbg_en` and `clamp` stay unchanged. `pwr_off` bit k clears 3 cycles after acceptance, and the reset is released with `done` 4+SHORT_CYC cycles after acceptance.
- R9: `busy` is high from acceptance to the last step. `done` is high for exactly one cycle after the last step. A start while busy has no effect.
- R10: A start in idle with index >= NUM_CORES raises `err` for one cycle and changes no register and no other output.
- R11: After reset, `busy`, `done` and `err` are 0 and `boot_addr_reg` is 0. Every per-core control bit (reset field, `l1_run`, `dbg_en`, `clamp`, `pwr_off`) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request |
| core_idx | input | IDX_W | Index of the core to bring up |
| boot_addr | input | ADDR_W | Boot address carried by the request |
| reduced_mode | input | 1 | 1 selects the reduced variant |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | One-cycle pulse on an out-of-range index |
| boot_addr_reg | output | ADDR_W | Shared private boot-address register |
| core_rst_ctrl | output | 2*NUM_CORES | Per-core reset fields, 2'b00 hold, 2'b11 run |
| l1_run | output | NUM_CORES | Per-core L1 cache run bit, 0 holds reset |
| dbg_en | output | NUM_CORES | Per-core external debug enable |
| clamp | output | CLAMP_W*NUM_CORES | Per-core power clamp fields |
| pwr_off | output | NUM_CORES | Per-core power-off gate, 1 gated |

## Verification
The bench builds the block with NUM_CORES = 3, LONG_CYC = 20 and SHORT_CYC = 5. With three cores the 2-bit index can carry the value 3, so the out-of-range error path is reachable. The short pauses let full and reduced sequences, back-to-back starts and a second boot of an already ramped core all fit in a few hundred cycles. A reference model in the bench predicts every output on every cycle from the timing offsets in the requirements.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HOLD,
      S_L1,
      S_DBG_OFF,
      S_CLAMP,
      S_WAIT_L,
      S_GATE,
      S_WAIT_S,
      S_RELEASE,
      S_DBG_ON
   } seq_state_e;

   // One strobe per kind of control write, valid for one cycle
   typedef struct packed {
      logic hold_rst;
      logic l1_clr;
      logic dbg_clr;
      logic clamp_wr;
      logic gate_clr;
      logic rel_rst;
      logic dbg_set;
   } seq_cmd_t;

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] val_i,
   output logic             expired_o
);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   // Counter parks at zero instead of wrapping
   p_cnt_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int IDX_W     = 2,
   parameter int CLAMP_W   = 8,
   parameter int LONG_CYC  = 16,
   parameter int SHORT_CYC = 4,
   parameter int DLY_W     = 5,
   parameter int SW        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             reduced_i,
   input  logic             expired_i,
   output logic             load_o,
   output logic [DLY_W-1:0] load_val_o,
   output seq_cmd_t         cmd_o,
   output logic [IDX_W-1:0] sel_o,
   output logic [SW-1:0]    step_o,
   output logic             accept_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);

   localparam logic [SW-1:0]    LAST_STEP = SW'(CLAMP_W);
   localparam logic [DLY_W-1:0] LONG_LD   = DLY_W'(LONG_CYC - 1);
   localparam logic [DLY_W-1:0] SHORT_LD  = DLY_W'(SHORT_CYC - 1);

   seq_state_e       state_q;
   logic [IDX_W-1:0] sel_q;
   logic             red_q;
   logic [SW-1:0]    step_q;
   logic             done_q;
   logic             err_q;
   logic             idx_ok;

   assign idx_ok   = (32'(idx_i) < NUM_CORES);
   assign accept_o = (state_q == S_IDLE) && start_i && idx_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         sel_q   <= '0;
         red_q   <= 1'b0;
         step_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  if (idx_ok) begin
                     sel_q   <= idx_i;
                     red_q   <= reduced_i;
                     state_q <= S_HOLD;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            S_HOLD:    state_q <= S_L1;
            S_L1:      state_q <= red_q ? S_GATE : S_DBG_OFF;
            S_DBG_OFF: begin
               step_q  <= '0;
               state_q <= S_CLAMP;
            end
            S_CLAMP: begin
               if (step_q == LAST_STEP) state_q <= S_WAIT_L;
               else                     step_q  <= step_q + 1'b1;
            end
            S_WAIT_L:  if (expired_i) state_q <= S_GATE;
            S_GATE:    state_q <= S_WAIT_S;
            S_WAIT_S:  if (expired_i) state_q <= S_RELEASE;
            S_RELEASE: begin
               if (red_q) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= S_DBG_ON;
               end
            end
            S_DBG_ON: begin
               state_q <= S_IDLE;
               done_q  <= 1'b1;
            end
            default:   state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_o = '0;
      case (state_q)
         S_HOLD:    cmd_o.hold_rst = 1'b1;
         S_L1:      cmd_o.l1_clr   = 1'b1;
         S_DBG_OFF: cmd_o.dbg_clr  = 1'b1;
         S_CLAMP:   cmd_o.clamp_wr = 1'b1;
         S_GATE:    cmd_o.gate_clr = 1'b1;
         S_RELEASE: cmd_o.rel_rst  = 1'b1;
         S_DBG_ON:  cmd_o.dbg_set  = 1'b1;
         default:   cmd_o = '0;
      endcase
   end

   assign load_o     = ((state_q == S_CLAMP) && (step_q == LAST_STEP)) || (state_q == S_GATE);
   assign load_val_o = (state_q == S_GATE) ? SHORT_LD : LONG_LD;
   assign sel_o      = sel_q;
   assign step_o     = step_q;
   assign busy_o     = (state_q != S_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;

   // Reduced sequences never reach the clamp or debug steps
   p_reduced_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      red_q |-> !(cmd_o.clamp_wr || cmd_o.dbg_clr || cmd_o.dbg_set));

   // The selected core does not change during a sequence
   p_sel_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(sel_q));

endmodule

// File: rtl/pwrseq_core_slice.sv
module pwrseq_core_slice
   import pwrseq_pkg::*;
#(
   parameter int CLAMP_W = 8,
   parameter int SW      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_i,
   input  seq_cmd_t           cmd_i,
   input  logic [SW-1:0]      step_i,
   output logic [1:0]         rst_ctrl_o,
   output logic               l1_run_o,
   output logic               dbg_en_o,
   output logic [CLAMP_W-1:0] clamp_o,
   output logic               pwr_off_o
);

   localparam logic [CLAMP_W-1:0] CLAMP_ALL = {CLAMP_W{1'b1}};

   logic [1:0]         rst_q;
   logic               l1_q;
   logic               dbg_q;
   logic [CLAMP_W-1:0] clamp_q;
   logic               off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q   <= 2'b11;
         l1_q    <= 1'b1;
         dbg_q   <= 1'b1;
         clamp_q <= CLAMP_ALL;
         off_q   <= 1'b1;
      end else if (sel_i) begin
         if (cmd_i.hold_rst) rst_q   <= 2'b00;
         if (cmd_i.rel_rst)  rst_q   <= 2'b11;
         if (cmd_i.l1_clr)   l1_q    <= 1'b0;
         if (cmd_i.dbg_clr)  dbg_q   <= 1'b0;
         if (cmd_i.dbg_set)  dbg_q   <= 1'b1;
         if (cmd_i.clamp_wr) clamp_q <= CLAMP_ALL >> step_i;
         if (cmd_i.gate_clr) off_q   <= 1'b0;
      end
   end

   assign rst_ctrl_o = rst_q;
   assign l1_run_o   = l1_q;
   assign dbg_en_o   = dbg_q;
   assign clamp_o    = clamp_q;
   assign pwr_off_o  = off_q;

   // Clamp opens one bit at a time, or restarts from fully closed
   p_clamp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clamp_q) |-> ((clamp_q == ($past(clamp_q) >> 1)) || (clamp_q == CLAMP_ALL)));

   // Gate is removed only with the clamp fully open or never ramped
   p_gate_after_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(off_q) |-> ((clamp_q == '0) || (clamp_q == CLAMP_ALL)));

   // Reset leaves the held state only once power is ungated
   p_release_powered_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((rst_q == 2'b11) && ($past(rst_q) == 2'b00)) |-> !off_q);

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
   import pwrseq_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 32,
   parameter int CLAMP_W   = 8,
   parameter int LONG_CYC  = 500000,
   parameter int SHORT_CYC = 50000,
   localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [IDX_W-1:0]             core_idx,
   input  logic [ADDR_W-1:0]            boot_addr,
   input  logic                         reduced_mode,
   output logic                         busy,
   output logic                         done,
   output logic                         err,
   output logic [ADDR_W-1:0]            boot_addr_reg,
   output logic [2*NUM_CORES-1:0]       core_rst_ctrl,
   output logic [NUM_CORES-1:0]         l1_run,
   output logic [NUM_CORES-1:0]         dbg_en,
   output logic [CLAMP_W*NUM_CORES-1:0] clamp,
   output logic [NUM_CORES-1:0]         pwr_off
);

   localparam int MAX_DLY = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int DLY_W   = $clog2(MAX_DLY + 1);
   localparam int SW      = $clog2(CLAMP_W + 1);

   if (NUM_CORES < 1) begin : g_bad_cores
      $error("NUM_CORES must be at least 1");
   end
   if (CLAMP_W < 1) begin : g_bad_clamp
      $error("CLAMP_W must be at least 1");
   end
   if ((LONG_CYC < 1) || (SHORT_CYC < 1)) begin : g_bad_delay
      $error("LONG_CYC and SHORT_CYC must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   seq_cmd_t         cmd;
   logic [IDX_W-1:0] sel;
   logic [SW-1:0]    step;
   logic             accept;
   logic             dly_load;
   logic [DLY_W-1:0] dly_val;
   logic             dly_expired;
   logic [ADDR_W-1:0] boot_q;

   pwrseq_fsm #(
      .NUM_CORES (NUM_CORES),
      .IDX_W     (IDX_W),
      .CLAMP_W   (CLAMP_W),
      .LONG_CYC  (LONG_CYC),
      .SHORT_CYC (SHORT_CYC),
      .DLY_W     (DLY_W),
      .SW        (SW)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .idx_i      (core_idx),
      .reduced_i  (reduced_mode),
      .expired_i  (dly_expired),
      .load_o     (dly_load),
      .load_val_o (dly_val),
      .cmd_o      (cmd),
      .sel_o      (sel),
      .step_o     (step),
      .accept_o   (accept),
      .busy_o     (busy),
      .done_o     (done),
      .err_o      (err)
   );

   pwrseq_delay #(
      .DLY_W (DLY_W)
   ) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (dly_load),
      .val_i     (dly_val),
      .expired_o (dly_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      boot_q <= '0;
      else if (accept) boot_q <= boot_addr;
   end
   assign boot_addr_reg = boot_q;

   for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
      pwrseq_core_slice #(
         .CLAMP_W (CLAMP_W),
         .SW      (SW)
      ) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel_i      (sel == IDX_W'(k)),
         .cmd_i      (cmd),
         .step_i     (step),
         .rst_ctrl_o (core_rst_ctrl[2*k +: 2]),
         .l1_run_o   (l1_run[k]),
         .dbg_en_o   (dbg_en[k]),
         .clamp_o    (clamp[CLAMP_W*k +: CLAMP_W]),
         .pwr_off_o  (pwr_off[k])
      );
   end

   // Boot address is frozen while a sequence runs
   p_boot_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(boot_addr_reg));

   // Done is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // Error is only reported from idle and starts nothing
   p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);

endmodule

// File: tb/tb_core_pwrup_seq.sv
module tb_core_pwrup_seq;

   localparam int NC = 3;
   localparam int AW = 32;
   localparam int CW = 8;
   localparam int LC = 20;
   localparam int SC = 5;
   localparam int IW = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [IW-1:0]      core_idx = '0;
   logic [AW-1:0]      boot_addr = '0;
   logic               reduced_mode = 1'b0;
   logic               busy, done, err;
   logic [AW-1:0]      boot_addr_reg;
   logic [2*NC-1:0]    core_rst_ctrl;
   logic [NC-1:0]      l1_run, dbg_en, pwr_off;
   logic [CW*NC-1:0]   clamp;

   always #10 clk = ~clk;

   core_pwrup_seq #(
      .NUM_CORES (NC), .ADDR_W (AW), .CLAMP_W (CW),
      .LONG_CYC (LC), .SHORT_CYC (SC)
   ) dut (
      .clk (clk), .rst_n (rst_n), .start (start), .core_idx (core_idx),
      .boot_addr (boot_addr), .reduced_mode (reduced_mode),
      .busy (busy), .done (done), .err (err), .boot_addr_reg (boot_addr_reg),
      .core_rst_ctrl (core_rst_ctrl), .l1_run (l1_run), .dbg_en (dbg_en),
      .clamp (clamp), .pwr_off (pwr_off)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // Behavioural reference model
   bit         m_busy, m_done, m_err, m_red;
   int         m_t, m_idx;
   logic [AW-1:0] m_boot;
   int         m_rst[NC], m_l1[NC], m_dbg[NC], m_clamp[NC], m_off[NC];

   task automatic model_reset();
      m_busy = 0; m_done = 0; m_err = 0; m_red = 0; m_t = 0; m_idx = 0; m_boot = '0;
      for (int k = 0; k < NC; k++) begin
         m_rst[k] = 3; m_l1[k] = 1; m_dbg[k] = 1; m_clamp[k] = 255; m_off[k] = 1;
      end
   endtask

   task automatic model_step();
      if (!rst_n) begin
         model_reset();
         return;
      end
      m_done = 0; m_err = 0;
      if (m_busy) begin
         m_t++;
         if (m_t == 1) m_rst[m_idx] = 0;
         if (m_t == 2) m_l1[m_idx] = 0;
         if (!m_red) begin
            if (m_t == 3) m_dbg[m_idx] = 0;
            if (m_t >= 4 && m_t <= 4 + CW) m_clamp[m_idx] = 255 >> (m_t - 4);
            if (m_t == 13 + LC) m_off[m_idx] = 0;
            if (m_t == 14 + LC + SC) m_rst[m_idx] = 3;
            if (m_t == 15 + LC + SC) begin
               m_dbg[m_idx] = 1; m_done = 1; m_busy = 0;
            end
         end else begin
            if (m_t == 3) m_off[m_idx] = 0;
            if (m_t == 4 + SC) begin
               m_rst[m_idx] = 3; m_done = 1; m_busy = 0;
            end
         end
      end else if (start) begin
         if (int'(core_idx) < NC) begin
            m_busy = 1; m_t = 0; m_idx = int'(core_idx);
            m_red = reduced_mode; m_boot = boot_addr;
         end else begin
            m_err = 1;
         end
      end
   endtask

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   task automatic compare();
      logic [2*NC-1:0]  e_rst;
      logic [NC-1:0]    e_l1, e_dbg, e_off;
      logic [CW*NC-1:0] e_clamp;
      for (int k = 0; k < NC; k++) begin
         e_rst[2*k +: 2]    = 2'(m_rst[k]);
         e_l1[k]            = 1'(m_l1[k]);
         e_dbg[k]           = 1'(m_dbg[k]);
         e_off[k]           = 1'(m_off[k]);
         e_clamp[CW*k +: CW] = CW'(m_clamp[k]);
      end
      chk("R1 boot_addr_reg", 64'(boot_addr_reg), 64'(m_boot));
      chk("R2/R7 core_rst_ctrl", 64'(core_rst_ctrl), 64'(e_rst));
      chk("R3 l1_run", 64'(l1_run), 64'(e_l1));
      chk("R4 dbg_en", 64'(dbg_en), 64'(e_dbg));
      chk("R5 clamp", 64'(clamp), 64'(e_clamp));
      chk("R6/R8 pwr_off", 64'(pwr_off), 64'(e_off));
      chk("R9 busy", 64'(busy), 64'(m_busy));
      chk("R9 done", 64'(done), 64'(m_done));
      chk("R10 err", 64'(err), 64'(m_err));
   endtask

   task automatic tick();
      @(negedge clk);
      model_step();
      compare();
   endtask

   task automatic req(int idx, logic [AW-1:0] addr, bit red);
      start = 1'b1; core_idx = IW'(idx); boot_addr = addr; reduced_mode = red;
      tick();
      start = 1'b0;
   endtask

   task automatic run_until_idle();
      for (int i = 0; i < 200 && (m_busy || busy); i++) tick();
      tick();
   endtask

   task automatic run_all();
      model_reset();
      for (int i = 0; i < 3; i++) tick();      // R11 reset state
      rst_n = 1'b1;
      tick();
      // R1..R7 full sequence on core 1, with an ignored start mid-way (R9)
      req(1, 32'h8000_1000, 1'b0);
      for (int i = 0; i < 10; i++) tick();
      req(2, 32'hDEAD_BEEF, 1'b1);
      run_until_idle();
      // R8 reduced sequence on core 2
      req(2, 32'h0000_4000, 1'b1);
      run_until_idle();
      // R10 out-of-range index
      req(3, 32'h1234_5678, 1'b0);
      tick(); tick();
      // R9 back-to-back: start held through done
      start = 1'b1; core_idx = 2'd0; boot_addr = 32'h0000_0100; reduced_mode = 1'b0;
      for (int i = 0; i < 45; i++) tick();
      start = 1'b0;
      run_until_idle();
      // R5 second full boot of an already ramped core
      req(1, 32'hCAFE_0000, 1'b0);
      run_until_idle();
      // R10 out of range from idle after everything
      req(3, 32'h0, 1'b1);
      tick();
   endtask

   initial begin
      bit wd_hit = 0;
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            wd_hit = 1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule